// File: doc/BRIEF.md
# Power-of-Two Card Clock Divider

This block derives a card-bus clock from the peripheral clock. A 4-bit select code picks a division ratio that is a power of two between 2 and 512. One reserved code instead passes the peripheral clock through undivided. The pass-through works only when a strap input says the chip supports it. The output has a 50% duty cycle. Each divided period starts with its low phase and ends with its high phase.

A companion strobe marks, in the peripheral-clock domain, the cycle before each rising edge of the output clock. Logic that runs on the peripheral clock can use it as a clock enable in step with the card clock.

The select code is taken up only at a period boundary, so the output never shows a shortened phase when the ratio changes. An enable input stops the output low and clears the divider. Typical settings are code 7 (divide by 256) during card identification and code 1 (divide by 4) for data transfer.

Top module: `card_clk_div`

## Requirements
- R1: Select code n in 0..8 gives an output period of 2^(n+1) peripheral cycles: 2^n cycles low, then 2^n cycles high.
- R2: Code 15 with `byp_ok_i` = 1 makes `clk_o` follow `clk_i`: high while `clk_i` is high and low while it is low.
- R3: Codes 9 to 14, and code 15 when `byp_ok_i` = 0, divide by 512 (256 cycles low, 256 cycles high).
- R4: A new select code is taken up only at the end of a high phase. The phase in progress finishes with its old length, and the next low phase uses the new ratio.
- R5: While `clk_en_i` = 0, `clk_o` and `rise_stb_o` are low, including with the pass-through code. After re-enable, the first low phase lasts a full 2^n cycles of the current select.
- R6: In divide mode, `rise_stb_o` is high for exactly one cycle per period: the last cycle of the low phase. In pass-through mode it is high every cycle while enabled.
- R7: During reset `clk_o` and `rise_stb_o` are low. The first period after reset uses code 7 (128 cycles low, 128 high), whatever the select input is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_en_i | input | 1 | Output clock enable |
| div_sel_i | input | 4 | Division select code |
| byp_ok_i | input | 1 | Strap: pass-through supported |
| clk_o | output | 1 | Divided card clock |
| rise_stb_o | output | 1 | One-cycle strobe ahead of each rising edge of `clk_o` |

## Verification
The assertions assume that `div_sel_i`, `byp_ok_i` and `clk_en_i` are synchronous to `clk_i`, so each is steady at every rising edge. The bench changes these inputs only 5 ns after a rising edge, well before the next falling or rising edge. `clk_en_i` may drop at any time, so the strobe-to-rise property includes the enable in its antecedent. The bench samples phase lengths once per cycle just after the rising edge. It checks the pass-through output at both clock levels, after a settling time long enough for any pending boundary.

// File: rtl/card_clk_div_pkg.sv
package card_clk_div_pkg;
  localparam int unsigned SEL_W = 4;
  localparam logic [SEL_W-1:0] BYP_CODE = '1;

  typedef struct packed {
    logic             byp;
    logic [SEL_W-1:0] n;
  } div_cfg_t;
endpackage

// File: rtl/card_clk_div_sel.sv
module card_clk_div_sel
  import card_clk_div_pkg::*;
#(
  parameter int unsigned MAX_CODE = 8,
  parameter int unsigned RST_CODE = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             byp_ok_i,
  input  logic             boundary_i,
  output div_cfg_t         cfg_o
);
  div_cfg_t dec, cfg_q;

  always_comb begin
    dec = '0;
    if (div_sel_i == BYP_CODE && byp_ok_i) begin
      dec.byp = 1'b1;
      dec.n   = SEL_W'(MAX_CODE);
    end else if (div_sel_i <= SEL_W'(MAX_CODE)) begin
      dec.n = div_sel_i;
    end else begin
      dec.n = SEL_W'(MAX_CODE);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.byp <= 1'b0;
      cfg_q.n   <= SEL_W'(RST_CODE);
    end else if (boundary_i) begin
      cfg_q <= dec;
    end
  end

  assign cfg_o = cfg_q;

  // R4
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_q) |-> $past(boundary_i));

  // R1
  always_comb begin
    n_range_chk: assert (!rst_ni || cfg_q.n <= SEL_W'(MAX_CODE));
  end
endmodule

// File: rtl/card_clk_div_cnt.sv
module card_clk_div_cnt
  import card_clk_div_pkg::*;
#(
  parameter int unsigned MAX_CODE = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             byp_i,
  input  logic [SEL_W-1:0] n_i,
  output logic             div_o,
  output logic             boundary_o,
  output logic             stb_o
);
  localparam int unsigned CNT_W = (MAX_CODE > 0) ? MAX_CODE : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   half;
  logic             div_q, wrap;

  assign half = (CNT_W+1)'(1) << n_i;
  assign wrap = ({1'b0, cnt_q} == half - (CNT_W+1)'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (!en_i || byp_i) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      div_q <= ~div_q;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // period ends as the high phase closes
  assign boundary_o = !en_i || byp_i || (wrap && div_q);
  assign stb_o      = en_i && (byp_i || (wrap && !div_q));
  assign div_o      = div_q;

  // R5
  dis_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!div_q && cnt_q == '0));

  // R6
  stb_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_o && !byp_i) |=> ($rose(div_q)));

  // R2
  byp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byp_i |=> !div_q);

  // R1
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, cnt_q} < half);
endmodule

// File: rtl/card_clk_div_out.sv
module card_clk_div_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic byp_i,
  input  logic div_i,
  output logic clk_o
);
  logic byp_nq;

  // retime on falling edge so the mux switches while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) byp_nq <= 1'b0;
    else         byp_nq <= byp_i && en_i;
  end

  assign clk_o = byp_nq ? clk_i : div_i;

  // R5
  byp_off_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !en_i |=> !byp_nq);
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
  import card_clk_div_pkg::*;
#(
  parameter int unsigned MAX_CODE = 8,
  parameter int unsigned RST_CODE = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_i,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             byp_ok_i,
  output logic             clk_o,
  output logic             rise_stb_o
);
  div_cfg_t cfg;
  logic     boundary, div_q;

  card_clk_div_sel #(.MAX_CODE(MAX_CODE), .RST_CODE(RST_CODE)) u_sel (
    .clk_i, .rst_ni, .div_sel_i, .byp_ok_i,
    .boundary_i (boundary),
    .cfg_o      (cfg)
  );

  card_clk_div_cnt #(.MAX_CODE(MAX_CODE)) u_cnt (
    .clk_i, .rst_ni,
    .en_i       (clk_en_i),
    .byp_i      (cfg.byp),
    .n_i        (cfg.n),
    .div_o      (div_q),
    .boundary_o (boundary),
    .stb_o      (rise_stb_o)
  );

  card_clk_div_out u_out (
    .clk_i, .rst_ni,
    .en_i  (clk_en_i),
    .byp_i (cfg.byp),
    .div_i (div_q),
    .clk_o
  );

  // R7
  rst_low_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!clk_o && !rise_stb_o));
endmodule

// File: tb/card_clk_div_tb.sv
`timescale 1ns/1ps
module card_clk_div_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       clk_en_i = 1'b1;
  logic [3:0] div_sel_i = 4'd2;
  logic       byp_ok_i = 1'b0;
  logic       clk_o, rise_stb_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  card_clk_div u_dut (.*);

  // entry: {code[3:0], strap, half[10:0]}; half 0 means pass-through
  localparam logic [15:0] VEC [14] = '{
    {4'd7,  1'b0, 11'd128}, {4'd1,  1'b0, 11'd2},   {4'd0,  1'b0, 11'd1},
    {4'd2,  1'b1, 11'd4},   {4'd3,  1'b0, 11'd8},   {4'd4,  1'b0, 11'd16},
    {4'd5,  1'b1, 11'd32},  {4'd6,  1'b0, 11'd64},  {4'd8,  1'b0, 11'd256},
    {4'd9,  1'b0, 11'd256}, {4'd14, 1'b1, 11'd256}, {4'd15, 1'b0, 11'd256},
    {4'd15, 1'b1, 11'd0},   {4'd1,  1'b1, 11'd2}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic smp();
    @(posedge clk_i);
    #5;
  endtask

  task automatic run_len(input logic lvl, output int len, output int stbs);
    len = 0; stbs = 0;
    while (clk_o === lvl && len < 2000) begin
      len++;
      if (rise_stb_o === 1'b1) stbs++;
      smp();
    end
  endtask

  task automatic sync_fall();
    for (int i = 0; i < 3000 && clk_o !== 1'b1; i++) smp();
    for (int i = 0; i < 3000 && clk_o === 1'b1; i++) smp();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 190000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int len, stbs, bad;
    #1 rst_ni = 1'b0;
    repeat (3) smp();
    // R7 reset state
    chk(clk_o === 1'b0 && rise_stb_o === 1'b0, "R7 reset outputs", {clk_o, rise_stb_o}, 0);
    rst_ni = 1'b1;
    run_len(1'b0, len, stbs);
    chk(len == 128, "R7 first low phase", len, 128);
    chk(stbs == 1, "R6 strobe after reset", stbs, 1);
    run_len(1'b1, len, stbs);
    chk(len == 128, "R7 first high phase", len, 128);
    run_len(1'b0, len, stbs);
    chk(len == 4, "R4 new code after boundary", len, 4);

    // table walk: R1 R2 R3 R6
    foreach (VEC[k]) begin
      int half;
      div_sel_i = VEC[k][15:12];
      byp_ok_i  = VEC[k][11];
      half      = int'(VEC[k][10:0]);
      if (half == 0) begin
        repeat (1100) smp();
        bad = 0;
        for (int c = 0; c < 4; c++) begin
          if (clk_o !== 1'b1 || rise_stb_o !== 1'b1) bad++;
          @(negedge clk_i); #5;
          if (clk_o !== 1'b0) bad++;
          smp();
        end
        chk(bad == 0, "R2 pass-through follows clk_i", bad, 0);
      end else begin
        sync_fall();
        sync_fall();
        run_len(1'b0, len, stbs);
        chk(len == half, (VEC[k][15:12] > 8) ? "R3 low phase" : "R1 low phase", len, half);
        chk(stbs == 1, "R6 one strobe in low phase", stbs, 1);
        run_len(1'b1, len, stbs);
        chk(len == half, (VEC[k][15:12] > 8) ? "R3 high phase" : "R1 high phase", len, half);
        chk(stbs == 0, "R6 no strobe in high phase", stbs, 0);
      end
    end

    // R4: change select in the middle of a high phase
    div_sel_i = 4'd3; byp_ok_i = 1'b0;
    sync_fall(); sync_fall();
    run_len(1'b0, len, stbs);
    div_sel_i = 4'd0;
    run_len(1'b1, len, stbs);
    chk(len == 8, "R4 high phase keeps old length", len, 8);
    run_len(1'b0, len, stbs);
    chk(len == 1, "R4 next low uses new code", len, 1);
    run_len(1'b1, len, stbs);
    chk(len == 1, "R4 next high uses new code", len, 1);

    // R5: disable in divide mode, then re-enable
    div_sel_i = 4'd2;
    clk_en_i  = 1'b0;
    smp(); smp();
    bad = 0;
    for (int c = 0; c < 10; c++) begin
      if (clk_o !== 1'b0 || rise_stb_o !== 1'b0) bad++;
      smp();
    end
    chk(bad == 0, "R5 outputs low while disabled", bad, 0);
    clk_en_i = 1'b1;
    run_len(1'b0, len, stbs);
    chk(len == 4, "R5 full low phase after enable", len, 4);
    chk(stbs == 1, "R6 strobe after enable", stbs, 1);

    // R5: disable with pass-through code
    div_sel_i = 4'd15; byp_ok_i = 1'b1;
    repeat (20) smp();
    clk_en_i = 1'b0;
    smp(); smp();
    bad = 0;
    for (int c = 0; c < 6; c++) begin
      if (clk_o !== 1'b0 || rise_stb_o !== 1'b0) bad++;
      @(negedge clk_i); #5;
      if (clk_o !== 1'b0) bad++;
      smp();
    end
    chk(bad == 0, "R5 pass-through gated off", bad, 0);
    clk_en_i = 1'b1;
    smp(); smp();
    chk(clk_o === 1'b1 && rise_stb_o === 1'b1, "R2 pass-through resumes", {clk_o, rise_stb_o}, 3);

    finish_run();
  end
endmodule